// File: doc/BRIEF.md
# Self-Latching Serial Segment Driver

This block takes a two-wire serial stream (a data line and a serial clock) and drives a bank of parallel active-low segment outputs, such as the cathodes of a common-anode LED display. No separate load or strobe line is needed. Each frame opens with a start bit of 1 and then carries one bit per output. When the last bit of a frame arrives, the collected bits move into an output latch and the shift stage clears for the next frame.

Both serial inputs come from a slow external master. They are brought into a faster system clock through flop synchronizers, and data is taken on each detected rising edge of the serial clock. A build option turns the highest output position into an enable input for the serial stream. In that build, serial clock edges that arrive while the enable is low are dropped, and the top output is held off. Only the digital framing, latching and output logic is modelled here.

Top module: `serial_seg_driver`

## Requirements
- R1: While reset is asserted and until the first complete frame, every bit of `seg_n` is 1 (all segments off), and the frame counter is idle.
- R2: Bit mapping: the k-th data bit after the start bit (k = 1..NUM_BITS) controls `seg_n[k-1]`, and a data value of 1 drives that output low (segment on).
- R3: The latch loads only on the rising serial clock edge that carries the last data bit (edge number NUM_BITS+1 of the frame). `seg_n` stays constant through all earlier edges of the frame.
- R4: While waiting for a start bit, rising serial clock edges with data 0 are discarded and do not begin a frame.
- R5: After a complete frame, the bit counter returns to idle and the shift stage is cleared. A partial frame is not cleared, so bits sent later continue and complete that same frame.
- R6: Frames sent back to back with no idle gap are each loaded in turn.
- R7: On a load, only the outputs whose new bit differs from the latched bit change, each with exactly one transition. A repeated frame causes no transition.
- R8: In the enable build (HAS_ENABLE = 1), rising serial clock edges seen while `ser_en` is low are ignored, and the bit count does not advance.
- R9: In the enable build, `seg_n[NUM_BITS-1]` is held at 1 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the master, asynchronous |
| ser_data | input | 1 | Serial data, taken on rising edges of ser_clk |
| ser_en | input | 1 | Serial enable, used only when HAS_ENABLE = 1 |
| seg_n | output | NUM_BITS | Active-low segment outputs |

## Verification
The hardest case to reach from the ports is a frame that is cut short and then resumed. The design must still be mid-frame with the latch untouched, and the bits that follow must finish that frame instead of starting a new one. The stimulus sends a start bit and ten data bits, checks that the outputs have not moved, and then sends the remaining bits. It expects the spliced vector to appear. The enable build gets a matching treatment: junk clock pulses are inserted with the enable low in the middle of a frame, and the clean frame must still land.

// File: rtl/ssd_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial segment driver.
package ssd_pkg;
    // Framer state: waiting for a start bit, or collecting data bits.
    typedef enum logic {
        FR_IDLE  = 1'b0,
        FR_SHIFT = 1'b1
    } fr_state_t;
endpackage

// File: rtl/ssd_sync.sv
`timescale 1ns/1ps
// ssd_sync: multi-stage flop synchronizer for a vector of independent
// single-bit asynchronous inputs.
// Assumes each bit is a slow level that can be sampled independently;
// no coherency between bits is implied.
module ssd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage captures the raw asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= async_i;
            end
        end else begin : g_rest
            // Later stages resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/ssd_frame.sv
`timescale 1ns/1ps
// ssd_frame: start-bit framer and shift stage.
// It waits for a rising serial edge that carries 1, then collects
// NUM_BITS data bits. On the edge that carries the last bit it pulses
// load_o with the assembled vector, and it clears its own counter and
// shift stage. Edges are qualified by en_i.
// Assumes synchronized inputs, with at least two system clocks between
// serial clock transitions.
module ssd_frame
    import ssd_pkg::*;
#(
    parameter int NUM_BITS = 35,
    parameter int CNT_W    = $clog2(NUM_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_i,
    input  logic                sdat_i,
    input  logic                en_i,
    output logic                load_o,
    output logic [NUM_BITS-1:0] frame_o,
    output logic [CNT_W-1:0]    cnt_o,
    output logic                busy_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BITS - 1);

    fr_state_t           state;
    logic [CNT_W-1:0]    cnt;
    logic [NUM_BITS-1:0] shreg;
    logic                sclk_d;
    logic                rise;

    // Delayed serial clock, used for rising edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_i;
    end

    assign rise = sclk_i & ~sclk_d & en_i;

    // Frame state, bit counter and shift stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FR_IDLE;
            cnt   <= '0;
            shreg <= '0;
        end else if (rise) begin
            case (state)
                FR_IDLE: begin
                    if (sdat_i) begin
                        state <= FR_SHIFT;
                        cnt   <= '0;
                    end
                end
                FR_SHIFT: begin
                    if (cnt == LAST) begin
                        state <= FR_IDLE;
                        cnt   <= '0;
                        shreg <= '0;
                    end else begin
                        shreg <= {sdat_i, shreg[NUM_BITS-1:1]};
                        cnt   <= cnt + 1'b1;
                    end
                end
                default: state <= FR_IDLE;
            endcase
        end
    end

    // Load strobe and assembled frame, both valid on the final edge.
    assign load_o  = rise && (state == FR_SHIFT) && (cnt == LAST);
    assign frame_o = {sdat_i, shreg[NUM_BITS-1:1]};
    assign cnt_o   = cnt;
    assign busy_o  = (state == FR_SHIFT);
endmodule

// File: rtl/ssd_outlatch.sv
`timescale 1ns/1ps
// ssd_outlatch: output latch with active-low drive.
// Each bit has its own flop, written only when a load brings a value
// that differs from the one held, so unchanged outputs never move.
// With HAS_ENABLE set, the top position is tied off (output high).
module ssd_outlatch #(
    parameter int NUM_BITS   = 35,
    parameter bit HAS_ENABLE = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [NUM_BITS-1:0] frame_i,
    output logic [NUM_BITS-1:0] seg_n_o
);
    localparam int DRIVEN = HAS_ENABLE ? NUM_BITS - 1 : NUM_BITS;

    logic [NUM_BITS-1:0] on_q;

    for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
        if (i < DRIVEN) begin : g_drv
            // Per-bit latch, written only on a differing load.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    on_q[i] <= 1'b0;
                else if (load_i && (frame_i[i] != on_q[i]))
                    on_q[i] <= frame_i[i];
            end
        end else begin : g_off
            assign on_q[i] = 1'b0;
        end
    end

    assign seg_n_o = ~on_q;
endmodule

// File: rtl/serial_seg_driver.sv
`timescale 1ns/1ps
// serial_seg_driver: top level of the self-latching serial segment
// driver. It synchronizes the serial pins, frames the stream on its
// start bit and drives active-low segment outputs from the latch.
// Assumes clk is at least several times faster than ser_clk.
module serial_seg_driver #(
    parameter int NUM_BITS    = 35,
    parameter bit HAS_ENABLE  = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk,
    input  logic                ser_data,
    input  logic                ser_en,
    output logic [NUM_BITS-1:0] seg_n
);
    localparam int CNT_W = $clog2(NUM_BITS);

    logic [2:0]          pins_s;
    logic                en_eff;
    logic                frame_load;
    logic [NUM_BITS-1:0] frame_vec;
    logic [CNT_W-1:0]    bit_cnt;
    logic                frame_busy;

    ssd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_en, ser_data, ser_clk}),
        .sync_o  (pins_s)
    );

    // The enable only takes effect in the enable build.
    assign en_eff = HAS_ENABLE ? pins_s[2] : 1'b1;

    ssd_frame #(.NUM_BITS(NUM_BITS), .CNT_W(CNT_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (pins_s[0]),
        .sdat_i  (pins_s[1]),
        .en_i    (en_eff),
        .load_o  (frame_load),
        .frame_o (frame_vec),
        .cnt_o   (bit_cnt),
        .busy_o  (frame_busy)
    );

    ssd_outlatch #(.NUM_BITS(NUM_BITS), .HAS_ENABLE(HAS_ENABLE)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (frame_load),
        .frame_i (frame_vec),
        .seg_n_o (seg_n)
    );
endmodule

// File: rtl/ssd_checker.sv
`timescale 1ns/1ps
// ssd_checker: protocol properties of serial_seg_driver, attached by bind.
module ssd_checker #(
    parameter int NUM_BITS   = 35,
    parameter bit HAS_ENABLE = 1'b0,
    parameter int CNT_W      = $clog2(NUM_BITS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_BITS-1:0] seg_n,
    input logic                load,
    input logic [CNT_W-1:0]    bit_cnt,
    input logic                busy,
    input logic                en_eff
);
    a_r1_reset_off: assert property (@(posedge clk) !rst_n |=> &seg_n);

    a_r3_change_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seg_n) |-> $past(load));

    a_r5_clear_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bit_cnt == '0) && !busy);

    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(bit_cnt) < NUM_BITS));

    a_r8_freeze_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_eff |=> $stable(bit_cnt) && $stable(busy));

    a_r9_top_held_off: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_ENABLE != 1'b0) |-> seg_n[NUM_BITS-1]);
endmodule

bind serial_seg_driver ssd_checker #(.NUM_BITS(NUM_BITS), .HAS_ENABLE(HAS_ENABLE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .seg_n   (seg_n),
    .load    (frame_load),
    .bit_cnt (bit_cnt),
    .busy    (frame_busy),
    .en_eff  (en_eff)
);

// File: tb/tb_serial_seg_driver.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected frames into a queue and
// a monitor pops and compares them once each load has settled.
module tb_serial_seg_driver;
    localparam int NB = 35;

    typedef struct packed {
        logic [NB-1:0] seg;
        logic [NB-1:0] seg_en;
        logic          chk_main;
        logic [31:0]   tog_exp;
        logic [31:0]   tog_start;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_en = 1'b1;
    logic [NB-1:0] seg_main;
    logic [NB-1:0] seg_var;

    int n_checks = 0;
    int n_errors = 0;
    int frames_sent = 0;
    int frames_seen = 0;
    int toggles = 0;
    logic [NB-1:0] prev_main = '1;
    logic [NB-1:0] last_main = '1;
    bit finished = 1'b0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    serial_seg_driver #(.NUM_BITS(NB), .HAS_ENABLE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(1'b1), .seg_n(seg_main)
    );

    serial_seg_driver #(.NUM_BITS(NB), .HAS_ENABLE(1'b1)) dut_en (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(ser_en), .seg_n(seg_var)
    );

    // Count output transitions of the main instance (R7).
    always @(negedge clk) begin
        if (rst_n) toggles = toggles + $countones(seg_main ^ prev_main);
        prev_main = seg_main;
    end

    task automatic chk(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One serial bit: data set up, rising edge, hold, falling edge.
    task automatic send_bit(input logic b);
        ser_data = b;
        repeat (10) @(negedge clk);
        ser_clk = 1'b1;
        repeat (20) @(negedge clk);
        ser_clk = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic push_expect(input logic [NB-1:0] v, input logic main, input int tstart);
        exp_t e;
        e.seg       = ~v;
        e.seg_en    = ~v | (NB'(1) << (NB - 1));
        e.chk_main  = main;
        e.tog_exp   = $countones(last_main ^ ~v);
        e.tog_start = tstart;
        if (main) last_main = ~v;
        exp_q.push_back(e);
        frames_sent++;
    endtask

    // Full frame, with a mid-frame check before the last bit (R3).
    task automatic send_frame(input logic [NB-1:0] v, input string tag);
        int ts;
        ts = toggles;
        send_bit(1'b1);
        for (int i = 0; i < NB - 1; i++) send_bit(v[i]);
        #1;
        chk({"R3 no load before last bit (", tag, ")"}, seg_main, last_main);
        send_bit(v[NB-1]);
        push_expect(v, 1'b1, ts);
    endtask

    // Monitor: pop and compare once each load has settled.
    initial begin
        forever begin
            exp_t e;
            wait (frames_sent > frames_seen);
            repeat (2) @(negedge clk);
            #1;
            e = exp_q.pop_front();
            frames_seen++;
            if (e.chk_main) begin
                chk("R2 R3 R6 main latch", seg_main, e.seg);
                chk_int("R7 transitions", toggles - int'(e.tog_start), int'(e.tog_exp));
            end
            chk("R2 R9 enable-build latch", seg_var, e.seg_en);
        end
    end

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [NB-1:0] fa, fb, fp, fc;
        int ts;
        fa = 35'h4_9B3C_5E7D;
        fb = 35'h7_1234_8765;
        fp = 35'h2_F0F0_1357;
        fc = 35'h5_5AA5_33CC;

        repeat (10) @(negedge clk);
        #1;
        chk("R1 reset main", seg_main, '1);
        chk("R1 reset enable-build", seg_var, '1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        chk("R1 after reset main", seg_main, '1);

        // R4: leading zeros must not start a frame.
        repeat (3) send_bit(1'b0);
        send_frame(fa, "A after zeros R4");
        // R6: back-to-back frames; R7 Hamming transitions.
        send_frame(fb, "B");
        send_frame(fb, "B repeat R7");

        // R5: truncated frame, then the continuation completes it.
        ts = toggles;
        send_bit(1'b1);
        for (int i = 0; i < 10; i++) send_bit(fp[i]);
        repeat (40) @(negedge clk);
        #1;
        chk("R5 partial frame main unchanged", seg_main, last_main);
        chk("R5 partial frame enable-build unchanged", seg_var, last_main | (NB'(1) << (NB - 1)));
        for (int i = 10; i < NB; i++) send_bit(fp[i]);
        push_expect(fp, 1'b1, ts);
        wait (frames_seen == frames_sent);

        // R8: junk edges with the enable low (enable build only from here).
        send_bit(1'b1);
        for (int i = 0; i < 15; i++) send_bit(fc[i]);
        ser_en = 1'b0;
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        #1;
        chk("R8 enable-build unchanged while disabled", seg_var, last_main | (NB'(1) << (NB - 1)));
        ser_en = 1'b1;
        for (int i = 15; i < NB; i++) send_bit(fc[i]);
        push_expect(fc, 1'b0, toggles);
        wait (frames_seen == frames_sent);

        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule